// File: doc/BRIEF.md
# Receive Byte Queue with Ready Pulse

This block holds received bytes between a serial receive deserializer and a register interface. Each byte that the deserializer presents with a valid strobe is stored in a small circular queue. The oldest unread byte is always visible on the data output. A read strobe from the bus consumes it, but only while the receiver is in the started state.

Each time a byte is accepted, the block emits a one-cycle pulse toward the event register logic. It emits the same pulse after every consuming read that leaves bytes unread, so software that clears the event after each read is told about the next byte. The free-space output feeds upstream flow control. It reports the number of empty slots while the receiver is started and zero while it is stopped.

Top module: `rx_hold_queue`

## Requirements
- R1: After reset the queue is empty. `ready_pulse` is low, and `free_space` equals DEPTH (6 by default) once `started` is high.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest unread byte without delay, before the read strobe.
- R3: A byte offered while the queue is not full is stored, and `ready_pulse` is high for exactly the one cycle after the accepting clock edge.
- R4: A byte offered while the queue holds DEPTH bytes is discarded. The stored contents and `free_space` are unchanged, and no pulse results.
- R5: A read strobe while `started` is low neither advances the oldest byte nor changes the fill level.
- R6: A consuming read that leaves at least one byte unread produces a one-cycle `ready_pulse`. A read that empties the queue produces none.
- R7: `free_space` equals DEPTH minus the fill level while `started` is high, and is 0 while it is low.
- R8: A byte arrival and a consuming read in the same cycle leave the fill level unchanged, and both take effect.
- R9: Storage positions wrap modulo DEPTH, including a DEPTH that is not a power of two, without disturbing order.
- R10: A read strobe on an empty queue changes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer has a byte this cycle |
| rx_byte | input | 8 | Received byte |
| started | input | 1 | Receiver started state |
| rd_strobe | input | 1 | Bus read of the receive data register |
| rd_data | output | 8 | Oldest unread byte |
| ready_pulse | output | 1 | One-cycle request to set the receive-ready event |
| free_space | output | $clog2(DEPTH+1) | Empty slots for flow control, 0 when stopped |

## Verification
The bench fills the queue and then offers one more byte. A design that overwrote the oldest entry instead of dropping the byte would return the wrong first byte on drain. Reads issued while stopped and reads issued while empty catch a head that advances without checking the state or the fill level. The tests track the pulse after each read: a design that fires only on arrival would miss the pulse after a pop, and one that fires on every read would pulse when the queue empties. Simultaneous arrive-and-read, and enough traffic to cross the end of a six-slot store, expose errors in the fill arithmetic and in non-power-of-two wrapping.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] rxq_byte_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic          started,
   output logic [PW-1:0] head_o,
   output logic [PW-1:0] widx_o,
   output logic [CW-1:0] count_o,
   output logic          push_ok_o,
   output logic          pop_ok_o,
   output logic          more_o
);
   localparam int unsigned SW = ((PW > CW) ? PW : CW) + 1;
   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [PW-1:0] head_q, head_inc;
   logic [CW-1:0] count_q, count_nxt;
   logic [SW-1:0] slot_sum;
   logic          full, empty;

   assign full      = (count_q == CW'(DEPTH));
   assign empty     = (count_q == '0);
   assign push_ok_o = push_req && !full;
   assign pop_ok_o  = pop_req && started && !empty;
   assign slot_sum  = SW'(head_q) + SW'(count_q);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_ctrl: DEPTH must be at least 2");
      end
      if (IS_POW2) begin : g_wrap_mask
         assign widx_o   = slot_sum[PW-1:0];
         assign head_inc = head_q + 1'b1;
      end else begin : g_wrap_cmp
         assign widx_o   = (slot_sum >= SW'(DEPTH)) ? PW'(slot_sum - SW'(DEPTH)) : PW'(slot_sum);
         assign head_inc = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      end
   endgenerate

   always_comb begin
      count_nxt = count_q;
      case ({push_ok_o, pop_ok_o})
         2'b10:   count_nxt = count_q + 1'b1;
         2'b01:   count_nxt = count_q - 1'b1;
         default: count_nxt = count_q;
      endcase
   end

   assign more_o = pop_ok_o && (count_nxt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         count_q <= count_nxt;
         if (pop_ok_o) head_q <= head_inc;
      end
   end

   assign head_o  = head_q;
   assign count_o = count_q;

   // R4
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   // R5
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!started && !push_req) |=> ($stable(head_q) && $stable(count_q)));
   // R4
   full_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop_ok_o) |=> (count_q == CW'(DEPTH)));
   // R8
   both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok_o && pop_ok_o) |=> $stable(count_q));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               we,
   input  logic [PW-1:0]      widx,
   input  rxq_pkg::rxq_byte_t wdata,
   input  logic [PW-1:0]      ridx,
   output rxq_pkg::rxq_byte_t rdata
);
   rxq_pkg::rxq_byte_t slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (we && (widx == PW'(i))) slot[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = (int'(ridx) < DEPTH) ? slot[ridx] : '0;
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic          started,
   input  logic          rd_strobe,
   output logic [7:0]    rd_data,
   output logic          ready_pulse,
   output logic [CW-1:0] free_space
);
   logic [PW-1:0] head, widx;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok, more;
   logic          ready_q;

   rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .push_req(rx_valid), .pop_req(rd_strobe),
      .started(started), .head_o(head), .widx_o(widx), .count_o(count),
      .push_ok_o(push_ok), .pop_ok_o(pop_ok), .more_o(more)
   );

   rxq_store #(.DEPTH(DEPTH)) i_store (
      .clk(clk), .we(push_ok), .widx(widx), .wdata(rx_byte),
      .ridx(head), .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= push_ok | more;
   end

   assign ready_pulse = ready_q;
   assign free_space  = started ? (CW'(DEPTH) - count) : '0;

   // R3
   arrive_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> ready_pulse);
   // R6
   drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && count == CW'(1) && !push_ok) |=> !ready_pulse);
   // R6
   refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && count > CW'(1)) |=> ready_pulse);
   // R10
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !rx_valid) |=> !ready_pulse);
endmodule

// File: tb/test_rx_hold_queue.sv
`timescale 1ns/1ps
module test_rx_hold_queue;
   localparam int DEPTH = 6;
   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 1'b0, started = 1'b0, rd_strobe = 1'b0;
   logic [7:0] rx_byte = '0, rd_data;
   logic ready_pulse;
   logic [2:0] free_space;
   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] model[$];

   always #2 clk = ~clk;

   rx_hold_queue #(.DEPTH(DEPTH)) i_rx_hold_queue (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .started(started), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .ready_pulse(ready_pulse), .free_space(free_space));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, output bit rdy);
      @(negedge clk); rx_valid = 1; rx_byte = b;
      @(negedge clk); rdy = ready_pulse; rx_valid = 0;
      if (model.size() < DEPTH) model.push_back(b);
   endtask

   task automatic rd(output logic [7:0] d, output bit rdy);
      @(negedge clk); d = rd_data; rd_strobe = 1;
      @(negedge clk); rdy = ready_pulse; rd_strobe = 0;
      if (started && model.size() > 0) void'(model.pop_front());
   endtask

   task automatic drain(input string tag);
      logic [7:0] d; bit r;
      while (model.size() > 0) begin
         int exp_rdy = (model.size() > 1);
         logic [7:0] e = model[0];
         rd(d, r);
         check(d == e, tag, d, e);
         check(r == exp_rdy, {tag, " pulse"}, r, exp_rdy);
      end
      check(free_space == DEPTH, {tag, " empty"}, free_space, DEPTH);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(ready_pulse == 0, "R1 pulse", ready_pulse, 0);
      check(free_space == 0, "R7 stopped", free_space, 0);
      started = 1;
      #0.1 check(free_space == DEPTH, "R1 free", free_space, DEPTH);
   endtask

   task automatic t_order;
      bit r;
      push(8'h11, r); check(r == 1, "R3 pulse", r, 1);
      @(negedge clk); check(ready_pulse == 0, "R3 one cycle", ready_pulse, 0);
      check(rd_data == 8'h11, "R2 visible", rd_data, 8'h11);
      push(8'h22, r); push(8'h33, r);
      check(free_space == DEPTH - 3, "R7 level", free_space, DEPTH - 3);
      drain("R2 R6 order");
   endtask

   task automatic t_full;
      bit r;
      for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i), r);
      check(free_space == 0, "R4 full", free_space, 0);
      push(8'hEE, r);
      check(r == 0, "R4 no pulse", r, 0);
      check(free_space == 0, "R4 level", free_space, 0);
      check(rd_data == 8'hA0, "R4 oldest kept", rd_data, 8'hA0);
      drain("R4 drain");
   endtask

   task automatic t_stopped;
      bit r; logic [7:0] d;
      push(8'h5A, r); push(8'h6B, r);
      started = 0;
      rd(d, r);
      check(r == 0, "R5 no pulse", r, 0);
      check(free_space == 0, "R7 stopped", free_space, 0);
      check(rd_data == 8'h5A, "R5 head held", rd_data, 8'h5A);
      started = 1;
      #0.1 check(free_space == DEPTH - 2, "R5 level", free_space, DEPTH - 2);
      drain("R5 R6 drain");
   endtask

   task automatic t_both;
      bit r;
      push(8'h01, r); push(8'h02, r);
      @(negedge clk); rx_valid = 1; rx_byte = 8'h03; rd_strobe = 1;
      @(negedge clk); rx_valid = 0; rd_strobe = 0;
      void'(model.pop_front()); model.push_back(8'h03);
      check(ready_pulse == 1, "R8 pulse", ready_pulse, 1);
      check(free_space == DEPTH - 2, "R8 level", free_space, DEPTH - 2);
      check(rd_data == 8'h02, "R8 head", rd_data, 8'h02);
      drain("R8 drain");
   endtask

   task automatic t_wrap;
      bit r; logic [7:0] d;
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 4; i++) push(8'(16 * k + i + 64), r);
         for (int i = 0; i < 2; i++) begin
            logic [7:0] e = model[0];
            rd(d, r); check(d == e, "R9 wrap", d, e);
         end
      end
      drain("R9 drain");
   endtask

   task automatic t_empty;
      bit r; logic [7:0] d;
      rd(d, r);
      check(r == 0, "R10 pulse", r, 0);
      check(free_space == DEPTH, "R10 level", free_space, DEPTH);
      push(8'h77, r);
      check(rd_data == 8'h77, "R10 next byte", rd_data, 8'h77);
      drain("R10 drain");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset; t_order; t_full; t_stopped; t_both; t_wrap; t_empty;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule